// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock with Match Interrupt

This peripheral keeps a 32-bit count of elapsed seconds and exposes it on a small 32-bit register bus. The count moves forward by one whenever an external one-cycle tick pulse arrives. That pulse is expected to come from a 1 Hz strobe that is already in this clock domain. Software can preset the count through a load register. It can also program a match value. When the count reaches the match value, a status bit is set, and that bit can be masked through to a single interrupt line.

The bus carries a select, a write enable, a word address, write data, read data and a ready handshake. A request is taken when select is high and ready is low. Ready then rises for one cycle, and read data is valid during that cycle. The control register cannot be switched off and always reads as enabled. The status-clear register only accepts writes. The top 32 bytes of the 4 KB window return fixed identification bytes, one byte in each word.

Top module: `rtc_seconds_timer`

## Requirements
- R1: After reset, the count, match, load, mask and raw status are all 0, irq_out is low, and bus_ready is low.
- R2: A request is accepted on a rising edge where bus_sel is 1 and bus_ready is 0. bus_ready is 1 on the next cycle, and for a read bus_rdata holds the register value from the accepting edge during that cycle. bus_ready is never high for two cycles in a row.
- R3: A write to offset 0x08 sets the seconds count to the written value, and reading 0x08 returns that value. When a load and a tick fall on the same edge, the load wins and the count takes the written value.
- R4: Reading offset 0x00 returns the seconds count. The count rises by 1 on each edge where tick_in is 1, and it wraps from 0xFFFFFFFF to 0.
- R5: Offset 0x04 holds the match value, and reading it returns the last value written.
- R6: A write to offset 0x10 keeps only bit 0 as the mask. Reading 0x10 returns that bit with bits 31:1 at zero.
- R7: Bit 0 of offset 0x14 (raw status) is set on the tick that moves the count onto the match value, and it stays set. A load that writes the match value does not set it.
- R8: Any write to offset 0x1C clears raw status. If a match occurs on the same edge as the clear, raw status stays set. Reading 0x1C returns 0.
- R9: Offset 0x18 reads raw status AND mask in bit 0, and irq_out always equals that bit.
- R10: Offset 0x0C always reads 1, and writes to it have no effect.
- R11: Word offsets 0xFE0 through 0xFFC each return one identification byte, zero-extended. From the lowest address upward the bytes are 0x31, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R12: Writes to the identification window or to unlisted offsets change no register. Reads of unlisted offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_in | input | 1 | One-cycle pulse that advances the seconds count |
| bus_sel | input | 1 | Access request, held until bus_ready is seen |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 12 | Byte address; bits 1:0 are ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_ready is high |
| bus_ready | output | 1 | One-cycle completion of an accepted request |
| irq_out | output | 1 | Masked match interrupt |

## Verification
The handshake assertions assume the requester holds bus_sel with stable address and data until it sees bus_ready, and then drops bus_sel for at least one cycle. The bench drives every access this way: it asserts select on a falling edge and releases it on the falling edge where ready is high. The counter assertions assume tick_in is a single-cycle pulse. The bench raises it either on its own or lined up with the accepting edge of a load or clear, which is how it reaches the load-versus-tick and clear-versus-match collisions.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    typedef enum logic [3:0] {
        RS_COUNT,
        RS_MATCH,
        RS_LOAD,
        RS_CTRL,
        RS_MASK,
        RS_RAW,
        RS_MASKED,
        RS_CLEAR,
        RS_IDENT,
        RS_NONE
    } reg_sel_e;

    // byte offsets inside the window
    localparam logic [11:0] OFS_COUNT  = 12'h000;
    localparam logic [11:0] OFS_MATCH  = 12'h004;
    localparam logic [11:0] OFS_LOAD   = 12'h008;
    localparam logic [11:0] OFS_CTRL   = 12'h00C;
    localparam logic [11:0] OFS_MASK   = 12'h010;
    localparam logic [11:0] OFS_RAW    = 12'h014;
    localparam logic [11:0] OFS_MASKED = 12'h018;
    localparam logic [11:0] OFS_CLEAR  = 12'h01C;

    localparam int ID_WORDS = 8;

endpackage

// File: rtl/rtc_addr_decode.sv
module rtc_addr_decode
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0]           addr,
    output reg_sel_e                    sel,
    output logic [$clog2(ID_WORDS)-1:0] id_idx
);
    localparam int WORD_W  = ADDR_W - 2;
    localparam int IDX_W   = $clog2(ID_WORDS);
    localparam int ID_BASE = (1 << WORD_W) - ID_WORDS;

    logic [WORD_W-1:0] word;
    logic [1:0]        unused_byte_lane;

    assign word             = addr[ADDR_W-1:2];
    assign unused_byte_lane = addr[1:0];
    assign id_idx           = word[IDX_W-1:0];

    always_comb begin
        sel = RS_NONE;
        if (int'(word) >= ID_BASE) begin
            sel = RS_IDENT;
        end else begin
            unique case (int'(word))
                int'(OFS_COUNT  >> 2): sel = RS_COUNT;
                int'(OFS_MATCH  >> 2): sel = RS_MATCH;
                int'(OFS_LOAD   >> 2): sel = RS_LOAD;
                int'(OFS_CTRL   >> 2): sel = RS_CTRL;
                int'(OFS_MASK   >> 2): sel = RS_MASK;
                int'(OFS_RAW    >> 2): sel = RS_RAW;
                int'(OFS_MASKED >> 2): sel = RS_MASKED;
                int'(OFS_CLEAR  >> 2): sel = RS_CLEAR;
                default:               sel = RS_NONE;
            endcase
        end
    end
endmodule

// File: rtl/rtc_id_rom.sv
module rtc_id_rom
    import rtc_pkg::*;
(
    input  logic [$clog2(ID_WORDS)-1:0] idx,
    output logic [7:0]                  id_byte
);
    always_comb begin
        unique case (idx)
            3'd0:    id_byte = 8'h31;
            3'd1:    id_byte = 8'h10;
            3'd2:    id_byte = 8'h14;
            3'd3:    id_byte = 8'h00;
            3'd4:    id_byte = 8'h0D;
            3'd5:    id_byte = 8'hF0;
            3'd6:    id_byte = 8'h05;
            default: id_byte = 8'hB1;
        endcase
    end
endmodule

// File: rtl/rtc_sec_counter.sv
module rtc_sec_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load_we,
    input  logic [CNT_W-1:0] load_val,
    input  logic             match_we,
    input  logic [CNT_W-1:0] match_val,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] load_reg,
    output logic [CNT_W-1:0] match_reg,
    output logic             hit
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] load;
        logic [CNT_W-1:0] match;
    } cnt_state_t;

    cnt_state_t       st_d, st_q;
    logic [CNT_W-1:0] inc_d;

    always_comb begin
        st_d  = st_q;
        hit   = 1'b0;
        inc_d = st_q.cnt + CNT_W'(1);
        if (match_we) st_d.match = match_val;
        if (load_we) begin
            st_d.load = load_val;
            st_d.cnt  = load_val;
        end else if (tick) begin
            st_d.cnt = inc_d;
            hit      = (inc_d == st_q.match);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count     = st_q.cnt;
    assign load_reg  = st_q.load;
    assign match_reg = st_q.match;

    // R4: a tick without a load steps the count by exactly one
    a_r4_tick_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load_we) |=> (count == $past(count) + CNT_W'(1)));
    // R3: a load places the written value in the count
    a_r3_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        load_we |=> (count == $past(load_val)));
    // R4: without tick or load the count holds
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load_we) |=> $stable(count));
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic mask_we,
    input  logic mask_bit,
    input  logic clr_we,
    output logic raw,
    output logic mask,
    output logic irq
);
    typedef struct packed {
        logic raw;
        logic mask;
    } irq_state_t;

    irq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (mask_we) st_d.mask = mask_bit;
        if (clr_we)  st_d.raw  = 1'b0;
        if (hit)     st_d.raw  = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign raw  = st_q.raw;
    assign mask = st_q.mask;
    assign irq  = st_q.raw & st_q.mask;

    // R7: a match sets raw status, also against a concurrent clear (R8)
    a_r7_hit_sets: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> raw);
    // R8: a clear with no match empties raw status
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && !hit) |=> !raw);
    // R7: raw status is sticky until cleared
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (raw && !clr_we) |=> raw);
endmodule

// File: rtl/rtc_seconds_timer.sv
module rtc_seconds_timer
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_in,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_ready,
    output logic              irq_out
);
    localparam int IDX_W = $clog2(ID_WORDS);

    typedef struct packed {
        logic              ready;
        logic [DATA_W-1:0] rdata;
    } bus_state_t;

    bus_state_t        bs_d, bs_q;
    reg_sel_e          rsel;
    logic [IDX_W-1:0]  id_idx;
    logic [7:0]        id_byte;
    logic              access, wr;
    logic [DATA_W-1:0] count, load_reg, match_reg;
    logic              hit, raw, mask, irq;

    assign access = bus_sel && !bs_q.ready;
    assign wr     = access && bus_we;

    rtc_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr   (bus_addr),
        .sel    (rsel),
        .id_idx (id_idx)
    );

    rtc_id_rom u_rom (
        .idx     (id_idx),
        .id_byte (id_byte)
    );

    rtc_sec_counter #(.CNT_W(DATA_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick_in),
        .load_we   (wr && rsel == RS_LOAD),
        .load_val  (bus_wdata),
        .match_we  (wr && rsel == RS_MATCH),
        .match_val (bus_wdata),
        .count     (count),
        .load_reg  (load_reg),
        .match_reg (match_reg),
        .hit       (hit)
    );

    rtc_irq_ctrl u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (hit),
        .mask_we  (wr && rsel == RS_MASK),
        .mask_bit (bus_wdata[0]),
        .clr_we   (wr && rsel == RS_CLEAR),
        .raw      (raw),
        .mask     (mask),
        .irq      (irq)
    );

    always_comb begin
        bs_d       = bs_q;
        bs_d.ready = access;
        if (access && !bus_we) begin
            unique case (rsel)
                RS_COUNT:  bs_d.rdata = count;
                RS_MATCH:  bs_d.rdata = match_reg;
                RS_LOAD:   bs_d.rdata = load_reg;
                RS_CTRL:   bs_d.rdata = DATA_W'(1);
                RS_MASK:   bs_d.rdata = DATA_W'(mask);
                RS_RAW:    bs_d.rdata = DATA_W'(raw);
                RS_MASKED: bs_d.rdata = DATA_W'(irq);
                RS_IDENT:  bs_d.rdata = DATA_W'(id_byte);
                default:   bs_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bs_q <= '0;
        else        bs_q <= bs_d;
    end

    assign bus_rdata = bs_q.rdata;
    assign bus_ready = bs_q.ready;
    assign irq_out   = irq;

    // R2: an accepted request completes on the next cycle
    a_r2_ready_follows: assert property (@(posedge clk) disable iff (!rst_n)
        access |=> bus_ready);
    // R2: ready is a single-cycle pulse
    a_r2_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready |=> !bus_ready);
    // R10: the control register reads as enabled
    a_r10_ctrl_one: assert property (@(posedge clk) disable iff (!rst_n)
        (access && !bus_we && rsel == RS_CTRL) |=> (bus_rdata == DATA_W'(1)));
    // R12: writes to the identification window leave the count-side registers alone
    a_r12_ident_ro: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && rsel == RS_IDENT) |=> ($stable(match_reg) && $stable(load_reg)));
endmodule

// File: tb/rtc_seconds_timer_test.sv
module rtc_seconds_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_in = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_ready;
    logic        irq_out;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    rtc_seconds_timer uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_in   (tick_in),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_ready (bus_ready),
        .irq_out   (irq_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic [11:0] a, input logic [31:0] d,
                          input logic tk, output logic [31:0] rd);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d; tick_in = tk;
        @(negedge clk);
        tick_in = 1'b0;
        chk("R2 ready after accept", {31'd0, bus_ready}, 32'd1);
        rd = bus_rdata;
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        logic [31:0] junk;
        access(1'b1, a, d, 1'b0, junk);
    endtask

    task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] v;
        access(1'b0, a, 32'd0, 1'b0, v);
        chk(tag, v, exp);
    endtask

    task automatic tick_once();
        @(negedge clk); tick_in = 1'b1;
        @(negedge clk); tick_in = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 ready low", {31'd0, bus_ready}, 32'd0);
        chk("R1 irq low", {31'd0, irq_out}, 32'd0);
        rd_chk("R1 count", 12'h000, 32'd0);
        rd_chk("R1 match", 12'h004, 32'd0);
        rd_chk("R1 load", 12'h008, 32'd0);
        rd_chk("R1 mask", 12'h010, 32'd0);
        rd_chk("R1 raw", 12'h014, 32'd0);
        @(negedge clk);
        chk("R2 ready single pulse", {31'd0, bus_ready}, 32'd0);
    endtask

    task automatic t_load_count();
        wr(12'h008, 32'd1000);
        rd_chk("R3 load readback", 12'h008, 32'd1000);
        rd_chk("R3 count after load", 12'h000, 32'd1000);
        tick_once(); tick_once(); tick_once();
        rd_chk("R4 count after 3 ticks", 12'h000, 32'd1003);
        rd_chk("R3 load unchanged by ticks", 12'h008, 32'd1000);
    endtask

    task automatic t_load_tick_race();
        logic [31:0] junk;
        access(1'b1, 12'h008, 32'd500, 1'b1, junk);
        rd_chk("R3 load beats tick", 12'h000, 32'd500);
    endtask

    task automatic t_wrap();
        wr(12'h008, 32'hFFFF_FFFF);
        tick_once();
        rd_chk("R4 wrap to zero", 12'h000, 32'd0);
    endtask

    task automatic t_match_mask();
        wr(12'h004, 32'hA5A5_1234);
        rd_chk("R5 match readback", 12'h004, 32'hA5A5_1234);
        wr(12'h010, 32'hFFFF_FFFE);
        rd_chk("R6 mask bit0 clear", 12'h010, 32'd0);
        wr(12'h010, 32'hFFFF_FFFF);
        rd_chk("R6 mask only bit0", 12'h010, 32'd1);
    endtask

    task automatic t_match_irq();
        wr(12'h01C, 32'd0);
        wr(12'h004, 32'd12);
        wr(12'h008, 32'd10);
        tick_once();
        rd_chk("R7 no set before match", 12'h014, 32'd0);
        tick_once();
        rd_chk("R7 raw set on match", 12'h014, 32'd1);
        rd_chk("R9 masked status", 12'h018, 32'd1);
        chk("R9 irq high", {31'd0, irq_out}, 32'd1);
        tick_once();
        rd_chk("R7 raw sticky", 12'h014, 32'd1);
        wr(12'h010, 32'd0);
        rd_chk("R9 masked off", 12'h018, 32'd0);
        chk("R9 irq follows mask", {31'd0, irq_out}, 32'd0);
        rd_chk("R9 raw kept under mask", 12'h014, 32'd1);
        wr(12'h01C, 32'h1234_5678);
        rd_chk("R8 clear any value", 12'h014, 32'd0);
        rd_chk("R8 clear reads zero", 12'h01C, 32'd0);
        wr(12'h010, 32'd1);
        wr(12'h008, 32'd12);
        rd_chk("R7 load to match no set", 12'h014, 32'd0);
        chk("R9 irq low no raw", {31'd0, irq_out}, 32'd0);
    endtask

    task automatic t_clear_race();
        logic [31:0] junk;
        wr(12'h004, 32'd21);
        wr(12'h008, 32'd20);
        access(1'b1, 12'h01C, 32'd0, 1'b1, junk);
        rd_chk("R8 match beats clear", 12'h014, 32'd1);
        wr(12'h01C, 32'd0);
        wr(12'h004, 32'd0);
        wr(12'h008, 32'hFFFF_FFFF);
        tick_once();
        rd_chk("R7 match at wrap", 12'h014, 32'd1);
        wr(12'h01C, 32'd0);
    endtask

    task automatic t_ctrl();
        rd_chk("R10 ctrl reads one", 12'h00C, 32'd1);
        wr(12'h00C, 32'd0);
        rd_chk("R10 ctrl write ignored", 12'h00C, 32'd1);
    endtask

    task automatic t_ident();
        logic [7:0] exp_id [8] = '{8'h31, 8'h10, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
        for (int i = 0; i < 8; i++)
            rd_chk("R11 id byte", 12'hFE0 + 12'(i * 4), {24'd0, exp_id[i]});
    endtask

    task automatic t_unmapped();
        wr(12'h008, 32'd77);
        wr(12'h004, 32'd88);
        wr(12'h010, 32'd1);
        wr(12'h020, 32'hDEAD_BEEF);
        wr(12'h800, 32'hDEAD_BEEF);
        wr(12'hFE0, 32'h0000_0000);
        wr(12'hFFC, 32'hFFFF_FFFF);
        rd_chk("R12 count kept", 12'h000, 32'd77);
        rd_chk("R12 match kept", 12'h004, 32'd88);
        rd_chk("R12 load kept", 12'h008, 32'd77);
        rd_chk("R12 mask kept", 12'h010, 32'd1);
        rd_chk("R12 raw kept", 12'h014, 32'd0);
        rd_chk("R12 id kept", 12'hFE0, 32'h31);
        rd_chk("R12 unlisted reads zero", 12'h020, 32'd0);
        rd_chk("R12 reserved reads zero", 12'hFDC, 32'd0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load_count();
        t_load_tick_race();
        t_wrap();
        t_match_mask();
        t_match_irq();
        t_clear_race();
        t_ctrl();
        t_ident();
        t_unmapped();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule